// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block picks the three divider settings of an integer-N clock synthesizer from two numbers: the reference frequency and the wanted output frequency, both in kHz. It chooses a reference divider M, a feedback multiplier N and a post divider PL. The output is ref*N/(M*PL). The block walks the candidates in a fixed order. It keeps the candidate whose rounded output is nearest the target, and every candidate it accepts respects the legal windows for the dividers, the comparison frequency ref/M and the oscillator frequency ref*N/M.

A request starts with a one-cycle `start` pulse. The engine then runs on its own while `busy` is high. It ends with a one-cycle `done` pulse, and the chosen M, N, PL, the achieved frequency and an error flag are valid in that same cycle. In best-fit mode the search continues until it finds an exact hit or runs out of candidates. With best-fit off, the search also stops at the first improving candidate that is close enough relative to its oscillator frequency. All divisions go through one shared serial divider. Window tests are done by multiply-compare.

Top module: `ppl_coef_search`

## Requirements
- R1: A `start` pulse while idle raises `busy` from the next cycle. `busy` stays high until the result is ready. `done` is then high for exactly one cycle, with `busy` low.
- R2: The target is clamped into the legal output window of 128000 to 2600000 kHz before the search begins.
- R3: The oscillator aim is T + floor(T/50), where T is the clamped target. The oscillator ceiling is the larger of 2600000 and that aim. PL is tried in ascending order from floor(1300000/aim) to ceil(ceiling/aim), and both bounds are clamped into 1 to 31.
- R4: For each PL, M rises from 1. The M scan for that PL stops once floor(ref/M) < 12000. An M with floor(ref/M) > 38400 is skipped.
- R5: For each M, the N candidates are floor and ceil of T*PL*M/ref, tried floor first. The M scan stops when the floor exceeds 255. Candidates below 8 are skipped, and a candidate above 255 ends the N trials for that M.
- R6: A candidate is accepted only when floor(ref*N/M) lies between 1300000 and the oscillator ceiling. Its output is floor((vco + floor(PL/2))/PL), and its error is the absolute difference from T.
- R7: A candidate replaces the kept one only when its error is strictly smaller. An error of zero ends the search at once.
- R8: With `best_fit` low, the search also ends when an improving candidate has floor(vco/error) > 218.
- R9: The reported frequency is floor(ref*N/(M*PL)) of the reported settings. On success, the reported M, N and PL lie within 1 to 255, 8 to 255 and 1 to 31.
- R10: If no candidate is accepted, `err` is 1, M, N, PL and the frequency are reported as 0, and `done` still pulses.
- R11: A `start` pulse while `busy` is high is ignored. It neither alters the running result nor queues a second search.
- R12: All result outputs and `err` change only in the cycle `done` is high. They keep their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, accepted when idle |
| ref_khz | input | 32 | Reference frequency in kHz |
| tgt_khz | input | 32 | Requested output frequency in kHz |
| best_fit | input | 1 | 1: search for the smallest error; 0: allow the early stop |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| m_out | output | 8 | Chosen reference divider |
| n_out | output | 8 | Chosen feedback multiplier |
| pl_out | output | 5 | Chosen post divider |
| freq_out | output | 32 | Achieved output frequency in kHz |
| err | output | 1 | No legal candidate was found |

## Verification
A wrong internal state shows up at the ports only at the next `done`, one full search later. This can be tens to thousands of cycles away. A bad window bound or a mis-stepped scan gives a different M/N/PL triple. It can also give a triple that breaks the comparison or oscillator window, and the bench recomputes those windows from the reported values. A broken early-exit rule or a broken strict-improvement rule changes which of two equal-error candidates comes out. Each search is therefore compared against an independent model that walks the same ordering. Handshake faults, such as a repeated `done`, a lost `busy` or a queued second start, are visible within one or two cycles of the pulse.

// File: rtl/ppl_pkg.sv
package ppl_pkg;
  // datapath width for products and quotients (covers 32-bit x 9-bit)
  localparam int PW = 48;

  typedef enum logic [3:0] {
    S_IDLE, S_T50, S_WHI, S_WLO, S_PL, S_MCHK,
    S_NDIV, S_NSEL, S_VDIV, S_ODIV, S_FDIV
  } ppl_state_e;
endpackage

// File: rtl/ppl_div.sv
// Restoring serial divider: one quotient bit per cycle, W cycles per divide.
module ppl_div #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_r, cnt_n;
  logic [W-1:0]  rem_r, rem_n, quo_r, quo_n, dvs_r, dvs_n;
  logic          busy_r, busy_n, done_r, done_n;
  logic [W:0]    trial;
  logic [W-1:0]  diff;
  logic          ge;

  always_comb begin
    trial  = {rem_r, quo_r[W-1]};
    ge     = (trial >= {1'b0, dvs_r});
    diff   = trial[W-1:0] - dvs_r;
    cnt_n  = cnt_r;
    rem_n  = rem_r;
    quo_n  = quo_r;
    dvs_n  = dvs_r;
    busy_n = busy_r;
    done_n = 1'b0;
    if (go && !busy_r) begin
      quo_n  = dividend;
      rem_n  = '0;
      dvs_n  = divisor;
      cnt_n  = CW'(W);
      busy_n = 1'b1;
    end else if (busy_r) begin
      rem_n = ge ? diff : trial[W-1:0];
      quo_n = {quo_r[W-2:0], ge};
      cnt_n = cnt_r - 1'b1;
      if (cnt_r == CW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      rem_r  <= '0;
      quo_r  <= '0;
      dvs_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      cnt_r  <= cnt_n;
      rem_r  <= rem_n;
      quo_r  <= quo_n;
      dvs_r  <= dvs_n;
      busy_r <= busy_n;
      done_r <= done_n;
    end
  end

  assign busy = busy_r;
  assign done = done_r;
  assign quot = quo_r;
  assign rem  = rem_r;

  AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_r |-> !busy_r); // R9
  AST_DIV_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n) done_r |=> !done_r); // R9
endmodule

// File: rtl/ppl_cand_chk.sv
// Multiply-compare window tests for one candidate.
module ppl_cand_chk #(
  parameter int PW         = 48,
  parameter int U_MIN      = 12000,
  parameter int U_MAX      = 38400,
  parameter int VCO_MIN    = 1300000,
  parameter int EXIT_RATIO = 218
) (
  input  logic [PW-1:0] ref_i,
  input  logic [PW-1:0] m_i,
  input  logic [PW-1:0] vco_new,
  input  logic [PW-1:0] vco_kept,
  input  logic [PW-1:0] vco_ceil,
  input  logic [PW-1:0] delta,
  output logic          u_low,
  output logic          u_high,
  output logic          vco_ok,
  output logic          ratio_hit
);
  always_comb begin
    // floor(ref/m) < U_MIN  <=> ref < U_MIN*m
    u_low     = ref_i < (PW'(U_MIN) * m_i);
    // floor(ref/m) > U_MAX  <=> ref >= (U_MAX+1)*m
    u_high    = ref_i >= (PW'(U_MAX + 1) * m_i);
    vco_ok    = (vco_new >= PW'(VCO_MIN)) && (vco_new <= vco_ceil);
    // floor(vco/d) > R  <=> vco >= (R+1)*d, for d > 0
    ratio_hit = vco_kept >= (PW'(EXIT_RATIO + 1) * delta);
  end
endmodule

// File: rtl/ppl_coef_search.sv
module ppl_coef_search
  import ppl_pkg::*;
#(
  parameter int FW         = 32,
  parameter int MW         = 8,
  parameter int NW         = 8,
  parameter int PLW        = 5,
  parameter int M_MIN      = 1,
  parameter int M_MAX      = 255,
  parameter int N_MIN      = 8,
  parameter int N_MAX      = 255,
  parameter int PL_MIN     = 1,
  parameter int PL_MAX     = 31,
  parameter int VCO_MIN    = 1300000,
  parameter int VCO_MAX    = 2600000,
  parameter int U_MIN      = 12000,
  parameter int U_MAX      = 38400,
  parameter int F_MIN      = 128000,
  parameter int F_MAX      = 2600000,
  parameter int TOL_DIV    = 50,
  parameter int EXIT_RATIO = 218
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [FW-1:0]  ref_khz,
  input  logic [FW-1:0]  tgt_khz,
  input  logic           best_fit,
  output logic           busy,
  output logic           done,
  output logic [MW-1:0]  m_out,
  output logic [NW-1:0]  n_out,
  output logic [PLW-1:0] pl_out,
  output logic [FW-1:0]  freq_out,
  output logic           err
);
  localparam int MCW  = MW + 1;
  localparam int NCW  = NW + 1;
  localparam int PLCW = PLW + 1;

  ppl_state_e st_r, st_n;
  logic [FW-1:0]   ref_r, ref_n, tgt_r, tgt_n;
  logic            bf_r, bf_n;
  logic [PW-1:0]   tvco_r, tvco_n, maxv_r, maxv_n, tv_r, tv_n, vco_r, vco_n, bd_r, bd_n;
  logic [PLCW-1:0] plhi_r, plhi_n, pl_r, pl_n;
  logic [MCW-1:0]  m_r, m_n;
  logic [NCW-1:0]  nc_r, nc_n, ncur_r, ncur_n;
  logic [MW-1:0]   bm_r, bm_n, mo_r, mo_n;
  logic [NW-1:0]   bn_r, bn_n, no_r, no_n;
  logic [PLW-1:0]  bp_r, bp_n, po_r, po_n;
  logic [FW-1:0]   fo_r, fo_n;
  logic            found_r, found_n, err_r, err_n, done_r, done_n;
  logic            dgo_r, dgo_n;
  logic [PW-1:0]   da_r, da_n, db_r, db_n;

  logic            dv_busy, dv_done;
  logic [PW-1:0]   dv_q, dv_rem;
  logic            u_low, u_high, vco_ok, ratio_hit;

  logic [PW-1:0]   tvco_c, maxv_c, delta_c;
  logic [FW-1:0]   tgt_cl;
  logic            fin, adv;

  function automatic logic [PLCW-1:0] clamp_pl(input logic [PW-1:0] v);
    if (v < PW'(PL_MIN))      return PLCW'(PL_MIN);
    else if (v > PW'(PL_MAX)) return PLCW'(PL_MAX);
    else                      return PLCW'(v);
  endfunction

  ppl_div #(.W(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(dgo_r), .dividend(da_r), .divisor(db_r),
    .busy(dv_busy), .done(dv_done), .quot(dv_q), .rem(dv_rem)
  );

  ppl_cand_chk #(
    .PW(PW), .U_MIN(U_MIN), .U_MAX(U_MAX), .VCO_MIN(VCO_MIN), .EXIT_RATIO(EXIT_RATIO)
  ) u_chk (
    .ref_i(PW'(ref_r)), .m_i(PW'(m_r)), .vco_new(dv_q), .vco_kept(vco_r),
    .vco_ceil(maxv_r), .delta(delta_c),
    .u_low(u_low), .u_high(u_high), .vco_ok(vco_ok), .ratio_hit(ratio_hit)
  );

  always_comb begin
    st_n = st_r;   ref_n = ref_r;   tgt_n = tgt_r;   bf_n = bf_r;
    tvco_n = tvco_r; maxv_n = maxv_r; tv_n = tv_r; vco_n = vco_r; bd_n = bd_r;
    plhi_n = plhi_r; pl_n = pl_r; m_n = m_r; nc_n = nc_r; ncur_n = ncur_r;
    bm_n = bm_r; bn_n = bn_r; bp_n = bp_r; found_n = found_r;
    mo_n = mo_r; no_n = no_r; po_n = po_r; fo_n = fo_r; err_n = err_r;
    done_n = 1'b0; dgo_n = 1'b0; da_n = da_r; db_n = db_r;
    fin = 1'b0; adv = 1'b0;

    tvco_c  = PW'(tgt_r) + dv_q;
    maxv_c  = (tvco_c > PW'(VCO_MAX)) ? tvco_c : PW'(VCO_MAX);
    delta_c = (dv_q >= PW'(tgt_r)) ? (dv_q - PW'(tgt_r)) : (PW'(tgt_r) - dv_q);
    if (tgt_khz < FW'(F_MIN))      tgt_cl = FW'(F_MIN);
    else if (tgt_khz > FW'(F_MAX)) tgt_cl = FW'(F_MAX);
    else                           tgt_cl = tgt_khz;

    case (st_r)
      S_IDLE: if (start) begin
        ref_n = ref_khz; tgt_n = tgt_cl; bf_n = best_fit;
        bd_n = '1; found_n = 1'b0;
        da_n = PW'(tgt_cl); db_n = PW'(TOL_DIV); dgo_n = 1'b1;
        st_n = S_T50;
      end
      S_T50: if (dv_done) begin
        tvco_n = tvco_c; maxv_n = maxv_c;
        da_n = maxv_c; db_n = tvco_c; dgo_n = 1'b1;
        st_n = S_WHI;
      end
      S_WHI: if (dv_done) begin
        plhi_n = clamp_pl(dv_q + PW'(dv_rem != '0));
        da_n = PW'(VCO_MIN); db_n = tvco_r; dgo_n = 1'b1;
        st_n = S_WLO;
      end
      S_WLO: if (dv_done) begin
        pl_n = clamp_pl(dv_q);
        st_n = S_PL;
      end
      S_PL: begin
        if (pl_r > plhi_r) fin = 1'b1;
        else begin
          tv_n = PW'(tgt_r) * PW'(pl_r);
          m_n  = MCW'(M_MIN);
          st_n = S_MCHK;
        end
      end
      S_MCHK: begin
        if ((m_r > MCW'(M_MAX)) || u_low) begin
          pl_n = pl_r + 1'b1; st_n = S_PL;
        end else if (u_high) begin
          m_n = m_r + 1'b1;
        end else begin
          da_n = tv_r * PW'(m_r); db_n = PW'(ref_r); dgo_n = 1'b1;
          st_n = S_NDIV;
        end
      end
      S_NDIV: if (dv_done) begin
        if (dv_q > PW'(N_MAX)) begin
          pl_n = pl_r + 1'b1; st_n = S_PL;
        end else begin
          ncur_n = NCW'(dv_q);
          nc_n   = NCW'(dv_q) + NCW'(dv_rem != '0);
          st_n   = S_NSEL;
        end
      end
      S_NSEL: begin
        if (ncur_r < NCW'(N_MIN)) adv = 1'b1;
        else if (ncur_r > NCW'(N_MAX)) begin
          m_n = m_r + 1'b1; st_n = S_MCHK;
        end else begin
          da_n = PW'(ref_r) * PW'(ncur_r); db_n = PW'(m_r); dgo_n = 1'b1;
          st_n = S_VDIV;
        end
      end
      S_VDIV: if (dv_done) begin
        vco_n = dv_q;
        if (vco_ok) begin
          da_n = dv_q + PW'(pl_r >> 1); db_n = PW'(pl_r); dgo_n = 1'b1;
          st_n = S_ODIV;
        end else adv = 1'b1;
      end
      S_ODIV: if (dv_done) begin
        if (delta_c < bd_r) begin
          bd_n = delta_c; found_n = 1'b1;
          bm_n = MW'(m_r); bn_n = NW'(ncur_r); bp_n = PLW'(pl_r);
          if ((delta_c == '0) || (!bf_r && ratio_hit)) fin = 1'b1;
          else adv = 1'b1;
        end else adv = 1'b1;
      end
      S_FDIV: if (dv_done) begin
        mo_n = bm_r; no_n = bn_r; po_n = bp_r; fo_n = FW'(dv_q);
        err_n = 1'b0; done_n = 1'b1;
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase

    if (adv) begin
      if (ncur_r < nc_r) begin
        ncur_n = nc_r; st_n = S_NSEL;
      end else begin
        m_n = m_r + 1'b1; st_n = S_MCHK;
      end
    end

    if (fin) begin
      if (found_n) begin
        da_n = PW'(ref_r) * PW'(bn_n); db_n = PW'(bm_n) * PW'(bp_n); dgo_n = 1'b1;
        st_n = S_FDIV;
      end else begin
        mo_n = '0; no_n = '0; po_n = '0; fo_n = '0;
        err_n = 1'b1; done_n = 1'b1;
        st_n = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r <= S_IDLE; ref_r <= '0; tgt_r <= '0; bf_r <= 1'b0;
      tvco_r <= '0; maxv_r <= '0; tv_r <= '0; vco_r <= '0; bd_r <= '1;
      plhi_r <= '0; pl_r <= '0; m_r <= '0; nc_r <= '0; ncur_r <= '0;
      bm_r <= '0; bn_r <= '0; bp_r <= '0; found_r <= 1'b0;
      mo_r <= '0; no_r <= '0; po_r <= '0; fo_r <= '0; err_r <= 1'b0; done_r <= 1'b0;
      dgo_r <= 1'b0; da_r <= '0; db_r <= '0;
    end else begin
      st_r <= st_n; ref_r <= ref_n; tgt_r <= tgt_n; bf_r <= bf_n;
      tvco_r <= tvco_n; maxv_r <= maxv_n; tv_r <= tv_n; vco_r <= vco_n; bd_r <= bd_n;
      plhi_r <= plhi_n; pl_r <= pl_n; m_r <= m_n; nc_r <= nc_n; ncur_r <= ncur_n;
      bm_r <= bm_n; bn_r <= bn_n; bp_r <= bp_n; found_r <= found_n;
      mo_r <= mo_n; no_r <= no_n; po_r <= po_n; fo_r <= fo_n; err_r <= err_n; done_r <= done_n;
      dgo_r <= dgo_n; da_r <= da_n; db_r <= db_n;
    end
  end

  assign busy     = (st_r != S_IDLE);
  assign done     = done_r;
  assign m_out    = mo_r;
  assign n_out    = no_r;
  assign pl_out   = po_r;
  assign freq_out = fo_r;
  assign err      = err_r;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_r |=> !done_r); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_r |-> (st_r == S_IDLE)); // R1
  AST_DIV_FREE: assert property (@(posedge clk) disable iff (!rst_n) dgo_r |-> !dv_busy); // R9
  AST_PL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (st_r == S_MCHK) |-> (pl_r >= PLCW'(PL_MIN) && pl_r <= PLCW'(PL_MAX))); // R3
  AST_LEGAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (done_r && !err_r) |-> (mo_r >= MW'(M_MIN) && no_r >= NW'(N_MIN) && po_r >= PLW'(PL_MIN) && po_r <= PLW'(PL_MAX))); // R9
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done_r && err_r) |-> (fo_r == '0 && mo_r == '0 && no_r == '0 && po_r == '0)); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_r |-> ($stable(mo_r) && $stable(no_r) && $stable(po_r) && $stable(fo_r) && $stable(err_r))); // R12
endmodule

// File: tb/sim_ppl_coef_search.sv
module sim_ppl_coef_search;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] ref_khz, tgt_khz;
  logic        best_fit;
  logic        busy, done, err;
  logic [7:0]  m_out, n_out;
  logic [4:0]  pl_out;
  logic [31:0] freq_out;

  int checks = 0;
  int failures = 0;
  bit abort = 1'b0;

  always #2 clk = ~clk;

  ppl_coef_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_khz(ref_khz), .tgt_khz(tgt_khz),
    .best_fit(best_fit), .busy(busy), .done(done), .m_out(m_out), .n_out(n_out),
    .pl_out(pl_out), .freq_out(freq_out), .err(err)
  );

  // {ref_khz, tgt_khz, best_fit}
  localparam int NV = 12;
  localparam logic [64:0] VEC [NV] = '{
    {32'd38400, 32'd998400,  1'b1},
    {32'd38400, 32'd1000000, 1'b0},
    {32'd38400, 32'd1000000, 1'b1},
    {32'd19200, 32'd700000,  1'b1},
    {32'd19200, 32'd700000,  1'b0},
    {32'd12000, 32'd1234567, 1'b1},
    {32'd50000, 32'd2600000, 1'b1},
    {32'd26000, 32'd128000,  1'b0},
    {32'd38400, 32'd3000000, 1'b1},
    {32'd13000, 32'd555555,  1'b0},
    {32'd38400, 32'd2500000, 1'b1},
    {32'd19200, 32'd333333,  1'b1}
  };

  // Independent model of the search order (R2..R10).
  task automatic model(input longint unsigned rf, input longint unsigned tg, input bit bf,
                       output longint unsigned em, output longint unsigned en,
                       output longint unsigned ep, output longint unsigned ef, output bit ee);
    longint unsigned t, aim, ceilv, hi, lo, best, tv, q, q2, vco, lwv, d;
    bit stop, fnd;
    t = (tg < 128000) ? 128000 : ((tg > 2600000) ? 2600000 : tg);        // R2
    aim = t + t / 50;                                                     // R3
    ceilv = (aim > 2600000) ? aim : 2600000;
    hi = (ceilv + aim - 1) / aim; if (hi < 1) hi = 1; if (hi > 31) hi = 31;
    lo = 1300000 / aim;           if (lo < 1) lo = 1; if (lo > 31) lo = 31;
    best = '1; stop = 0; fnd = 0; em = 0; en = 0; ep = 0;
    for (longint unsigned p = lo; p <= hi && !stop; p++) begin
      tv = t * p;
      for (longint unsigned m = 1; m <= 255 && !stop; m++) begin
        if (rf / m < 12000) break;                                        // R4
        if (rf / m > 38400) continue;
        q  = tv * m / rf;                                                 // R5
        q2 = (tv * m + rf - 1) / rf;
        if (q > 255) break;
        for (longint unsigned n = q; n <= q2 && !stop; n++) begin
          if (n < 8) continue;
          if (n > 255) break;
          vco = rf * n / m;                                               // R6
          if (vco >= 1300000 && vco <= ceilv) begin
            lwv = (vco + p / 2) / p;
            d = (lwv > t) ? lwv - t : t - lwv;
            if (d < best) begin                                           // R7
              best = d; em = m; en = n; ep = p; fnd = 1;
              if (d == 0 || (!bf && vco / d > 218)) stop = 1;             // R8
            end
          end
        end
      end
    end
    if (fnd) begin ef = rf * en / (em * ep); ee = 0; end                 // R9
    else begin em = 0; en = 0; ep = 0; ef = 0; ee = 1; end               // R10
  endtask

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    bit seen = 0;
    for (int c = 0; c < 60000; c++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    if (!seen) begin
      checks++; failures++; abort = 1;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    end
  endtask

  task automatic launch(input logic [31:0] rf, input logic [31:0] tg, input bit bf);
    ref_khz = rf; tgt_khz = tg; best_fit = bf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", busy, 1);
  endtask

  task automatic check_result(input logic [31:0] rf, input logic [31:0] tg, input bit bf);
    longint unsigned em, en, ep, ef, t, aim, ceilv, vco;
    bit ee;
    model(rf, tg, bf, em, en, ep, ef, ee);
    chk("R1 busy low at done", busy, 0);
    chk("R7 m", m_out, em);
    chk("R7 n", n_out, en);
    chk("R7 pl", pl_out, ep);
    chk("R8 freq", freq_out, ef);
    chk("R10 err", err, ee);
    if (!err && m_out != 0 && pl_out != 0) begin
      t = (tg < 128000) ? 128000 : ((tg > 2600000) ? 2600000 : tg);
      aim = t + t / 50;
      ceilv = (aim > 2600000) ? aim : 2600000;
      vco = longint'(rf) * n_out / m_out;
      chk("R4 comparison window", (rf / m_out >= 12000 && rf / m_out <= 38400), 1);
      chk("R5 n window", (n_out >= 8), 1);
      chk("R6 vco window", (vco >= 1300000 && vco <= ceilv), 1);
      chk("R9 freq formula", freq_out, longint'(rf) * n_out / (longint'(m_out) * pl_out));
    end
    @(negedge clk);
    chk("R1 done one cycle", done, 0);
  endtask

  initial begin
    logic [7:0] hm, hn; logic [4:0] hp; logic [31:0] hf; logic he;
    rst_n = 1'b0; start = 1'b0; ref_khz = '0; tgt_khz = '0; best_fit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R12 reset err", err, 0);
    chk("R12 reset freq", freq_out, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (!abort) begin
        launch(VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
        wait_done();
        if (!abort) check_result(VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
      end
    end

    // R7: exact hit, literal values
    if (!abort) begin
      launch(32'd38400, 32'd998400, 1'b0);
      wait_done();
      chk("R7 exact m", m_out, 1);
      chk("R7 exact n", n_out, 52);
      chk("R7 exact pl", pl_out, 2);
      chk("R7 exact freq", freq_out, 998400);
    end

    // R2: low target clamps to the 128000 result
    if (!abort) begin
      longint unsigned em, en, ep, ef; bit ee;
      model(38400, 128000, 1'b1, em, en, ep, ef, ee);
      launch(32'd38400, 32'd50000, 1'b1);
      wait_done();
      chk("R2 clamp n", n_out, en);
      chk("R2 clamp pl", pl_out, ep);
      chk("R2 clamp freq", freq_out, ef);
    end

    // R10: reference too slow for any M
    if (!abort) begin
      launch(32'd5000, 32'd800000, 1'b1);
      wait_done();
      chk("R10 err set", err, 1);
      chk("R10 freq zero", freq_out, 0);
      chk("R10 m zero", m_out, 0);
    end

    // R11: start while busy is ignored
    if (!abort) begin
      launch(32'd38400, 32'd1000000, 1'b1);
      @(negedge clk);
      ref_khz = 32'd19200; tgt_khz = 32'd700000; best_fit = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      if (!abort) begin
        check_result(32'd38400, 32'd1000000, 1'b1);
        repeat (4) @(negedge clk);
        chk("R11 no queued search", busy, 0);
      end
    end

    // R12: outputs held with inputs moving and no start
    if (!abort) begin
      hm = m_out; hn = n_out; hp = pl_out; hf = freq_out; he = err;
      ref_khz = 32'd12000; tgt_khz = 32'd2000000; best_fit = 1'b0;
      repeat (20) @(negedge clk);
      chk("R12 hold m", m_out, hm);
      chk("R12 hold n", n_out, hn);
      chk("R12 hold pl", pl_out, hp);
      chk("R12 hold freq", freq_out, hf);
      chk("R12 hold err", err, he);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule